// File: doc/BRIEF.md
# Handshaked Mailbox Register Block with Dual Interrupt Vectors

This block sits between a host processor and a communications coprocessor. The host sees a small register file on a word-wide bus. Word 0 is a control/status word, word 1 holds an instruction the host forces into the coprocessor in maintenance mode, word 2 holds the last word the coprocessor posted, and word 3 holds a command word for the coprocessor. The host changes any writable register with plain writes, bit-set or bit-clear writes under per-byte enables. It can also read a register or bit-test it against a mask.

The two sides hand commands across with ready flags. The input-ready flag says the coprocessor will take a command. The output-ready flag says the coprocessor has posted a result. Input readiness always interrupts on vector A and output readiness always on vector B. A flag stays set, and blocks further events of its kind, until the host clears it. So no handshake is lost or counted twice.

The coprocessor posts results through a valid/ready stream. The block accepts a word only while run is set and output-ready is clear. A word offered while output-ready is set waits, and the posted word is not replaced. The host must clear output-ready before the next transfer. The other coprocessor pins are plain levels and strobes.

Top module: `mbx_csr_irq`

## Requirements
- R1: After reset every register reads zero, both interrupt requests are low and `dev_out_ready` is low.
- R2: Bus operations use `bus_op` codes 0 read, 1 write, 2 bit-set, 3 bit-clear and 4 bit-test. Byte b of the word is affected only when `bus_be[b]` is 1. Bit-test returns the register ANDed with `bus_wdata` and changes nothing. Read data appears on `bus_rdata` one cycle after the request.
- R3: If the host raises the request-input bit (control bit 5) while run is set, the input-ready bit (bit 4, octal 20) is set on the next cycle. With the input enable (bit 0) set, `irq_a` rises on that same cycle.
- R4: Output transfers are valid/ready. `dev_out_ready` is high only while run is set and output-ready (bit 7, octal 200) is clear. A transfer sets output-ready, stores the data word in word 2, and with the output enable (bit 1) set raises `irq_b`.
- R5: While output-ready is set, an offered output word is not accepted. Word 2, the ready bit and the interrupt state do not change.
- R6: Input readiness only ever drives `irq_a` and output readiness only ever drives `irq_b`.
- R7: A request is high only while its ready bit and its enable bit are both set. If the enable is set later, a ready event still awaiting service raises the request.
- R8: An acknowledge pulse drops its request on the next cycle. The request does not return until the ready bit has been cleared and set again.
- R9: The host clears a ready bit by writing it to zero, and this removes its interrupt condition. Writing one to a ready bit has no effect.
- R10: Clearing run (bit 15) clears both ready bits and the request-input bit and drops both interrupts. While run is clear no output word is accepted.
- R11: Writing one to the step bit (bit 8, octal 400) while the maintenance bit (bit 9, octal 1000) is set gives a one-cycle `dev_step` pulse, and no pulse without it. The step bit reads as zero. Word 1 drives `dev_instr`.
- R12: A `dev_in_grant` pulse sets input-ready while run is set and input-ready is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Host access strobe, one cycle per access |
| bus_op | input | 3 | Access kind: read, write, set, clear, test |
| bus_addr | input | AW | Register word select |
| bus_be | input | DW/8 | Byte enables for write, set and clear |
| bus_wdata | input | DW | Write data or bit mask |
| bus_rdata | output | DW | Read or test result, registered |
| dev_run | output | 1 | Run bit to the coprocessor |
| dev_maint | output | 1 | Maintenance-instruction mode |
| dev_step | output | 1 | One-cycle execute strobe for the forced instruction |
| dev_instr | output | DW | Forced instruction word |
| dev_cmd | output | DW | Command word from the host |
| dev_req_in | output | 1 | Host request-input bit |
| dev_in_grant | input | 1 | Coprocessor grants input readiness |
| dev_out_valid | input | 1 | Coprocessor offers an output word |
| dev_out_data | input | DW | Output word |
| dev_out_ready | output | 1 | Output word will be accepted |
| irq_a | output | 1 | Vector A request (input ready) |
| irq_a_ack | input | 1 | Vector A acknowledge |
| irq_b | output | 1 | Vector B request (output ready) |
| irq_b_ack | input | 1 | Vector B acknowledge |

## Verification
The bench builds the block with its defaults, DW=16 and AW=2. With these values the 16-bit control word fills the whole bus word, and the per-byte enables split it into the status byte and the control byte. This lets the byte-masked set and clear cases work on each half separately. All four register words can be addressed, so the bench can check the posted output word directly after an attempted overrun and after a transfer offered while run is clear.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam logic [2:0] OP_READ  = 3'd0;
  localparam logic [2:0] OP_WRITE = 3'd1;
  localparam logic [2:0] OP_SET   = 3'd2;
  localparam logic [2:0] OP_CLEAR = 3'd3;
  localparam logic [2:0] OP_TEST  = 3'd4;

  localparam int B_IN_IE   = 0;
  localparam int B_OUT_IE  = 1;
  localparam int B_IN_RDY  = 4;
  localparam int B_REQ_IN  = 5;
  localparam int B_OUT_RDY = 7;
  localparam int B_STEP    = 8;
  localparam int B_MAINT   = 9;
  localparam int B_RUN     = 15;

  localparam int CSR_W = 16;
endpackage

// File: rtl/mbx_merge.sv
module mbx_merge #(
  parameter int DW = 16,
  localparam int NB = DW / 8
) (
  input  logic [2:0]    op,
  input  logic [NB-1:0] be,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] old,
  output logic [DW-1:0] merged
);
  import mbx_pkg::*;

  logic [DW-1:0] bmask;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign bmask[b*8 +: 8] = {8{be[b]}};
  end

  always_comb begin
    case (op)
      OP_WRITE: merged = (old & ~bmask) | (wdata & bmask);
      OP_SET:   merged = old | (wdata & bmask);
      OP_CLEAR: merged = old & ~(wdata & bmask);
      default:  merged = old;
    endcase
  end
endmodule

// File: rtl/mbx_vector.sv
module mbx_vector (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic clr_ev,
  input  logic rdy,
  input  logic ie,
  input  logic ack,
  output logic irq
);
  logic armed_q;

  assign irq = armed_q & rdy & ie;

  always_ff @(posedge clk) begin
    if (!rst_n)          armed_q <= 1'b0;
    else if (clr_ev)     armed_q <= 1'b0;
    else if (set_ev)     armed_q <= 1'b1;
    else if (ack && irq) armed_q <= 1'b0;
  end
endmodule

// File: rtl/mbx_csr_irq.sv
module mbx_csr_irq #(
  parameter int DW = 16,
  parameter int AW = 2,
  localparam int NB = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_req,
  input  logic [2:0]    bus_op,
  input  logic [AW-1:0] bus_addr,
  input  logic [NB-1:0] bus_be,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          dev_run,
  output logic          dev_maint,
  output logic          dev_step,
  output logic [DW-1:0] dev_instr,
  output logic [DW-1:0] dev_cmd,
  output logic          dev_req_in,
  input  logic          dev_in_grant,
  input  logic          dev_out_valid,
  input  logic [DW-1:0] dev_out_data,
  output logic          dev_out_ready,
  output logic          irq_a,
  input  logic          irq_a_ack,
  output logic          irq_b,
  input  logic          irq_b_ack
);
  import mbx_pkg::*;

  logic [CSR_W-1:0] csr_q, csr_nx;
  logic [DW-1:0]    instr_q, outbox_q, cmd_q;
  logic [DW-1:0]    csr_ext, cur, merged;
  logic             req_d_q, step_q;

  // current value of the addressed word
  always_comb begin
    csr_ext = '0;
    csr_ext[CSR_W-1:0] = csr_q;
    if (int'(bus_addr) == 0)      cur = csr_ext;
    else if (int'(bus_addr) == 1) cur = instr_q;
    else if (int'(bus_addr) == 2) cur = outbox_q;
    else if (int'(bus_addr) == 3) cur = cmd_q;
    else                          cur = '0;
  end

  mbx_merge #(.DW(DW)) u_merge (
    .op(bus_op), .be(bus_be), .wdata(bus_wdata), .old(cur), .merged(merged)
  );

  logic wr_en, hit_csr, hit_instr, hit_cmd;
  assign wr_en     = bus_req && (bus_op == OP_WRITE || bus_op == OP_SET || bus_op == OP_CLEAR);
  assign hit_csr   = wr_en && int'(bus_addr) == 0;
  assign hit_instr = wr_en && int'(bus_addr) == 1;
  assign hit_cmd   = wr_en && int'(bus_addr) == 3;

  logic [CSR_W-1:0] csr_new;
  assign csr_new = hit_csr ? merged[CSR_W-1:0] : csr_q;

  logic unused_bits;
  assign unused_bits = ^{csr_new[14:10], csr_new[6], csr_new[3:2], merged};

  logic run_n, req_rise, in_set, out_fire, in_rdy_nx, out_rdy_nx;
  assign run_n    = csr_new[B_RUN];
  assign req_rise = csr_q[B_REQ_IN] & ~req_d_q;
  assign in_set   = csr_q[B_RUN] & ~csr_q[B_IN_RDY] & (req_rise | dev_in_grant);
  assign dev_out_ready = csr_q[B_RUN] & ~csr_q[B_OUT_RDY];
  assign out_fire = dev_out_valid & dev_out_ready;
  // ready bits: the host may only clear them; events set them only while clear
  assign in_rdy_nx  = run_n & ((csr_q[B_IN_RDY]  & csr_new[B_IN_RDY])  | in_set);
  assign out_rdy_nx = run_n & ((csr_q[B_OUT_RDY] & csr_new[B_OUT_RDY]) | out_fire);

  always_comb begin
    csr_nx = '0;
    csr_nx[B_RUN]     = run_n;
    csr_nx[B_MAINT]   = csr_new[B_MAINT];
    csr_nx[B_IN_IE]   = csr_new[B_IN_IE];
    csr_nx[B_OUT_IE]  = csr_new[B_OUT_IE];
    csr_nx[B_REQ_IN]  = csr_new[B_REQ_IN] & run_n;
    csr_nx[B_IN_RDY]  = in_rdy_nx;
    csr_nx[B_OUT_RDY] = out_rdy_nx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csr_q     <= '0;
      req_d_q   <= 1'b0;
      step_q    <= 1'b0;
      instr_q   <= '0;
      outbox_q  <= '0;
      cmd_q     <= '0;
      bus_rdata <= '0;
    end else begin
      csr_q   <= csr_nx;
      req_d_q <= csr_q[B_REQ_IN];
      step_q  <= hit_csr & csr_new[B_STEP] & csr_new[B_MAINT];
      if (hit_instr) instr_q  <= merged;
      if (hit_cmd)   cmd_q    <= merged;
      if (out_fire)  outbox_q <= dev_out_data;
      if (bus_req && bus_op == OP_READ)      bus_rdata <= cur;
      else if (bus_req && bus_op == OP_TEST) bus_rdata <= cur & bus_wdata;
    end
  end

  mbx_vector u_vec_a (
    .clk(clk), .rst_n(rst_n),
    .set_ev(in_set & run_n), .clr_ev(csr_q[B_IN_RDY] & ~in_rdy_nx),
    .rdy(csr_q[B_IN_RDY]), .ie(csr_q[B_IN_IE]), .ack(irq_a_ack), .irq(irq_a)
  );

  mbx_vector u_vec_b (
    .clk(clk), .rst_n(rst_n),
    .set_ev(out_fire & run_n), .clr_ev(csr_q[B_OUT_RDY] & ~out_rdy_nx),
    .rdy(csr_q[B_OUT_RDY]), .ie(csr_q[B_OUT_IE]), .ack(irq_b_ack), .irq(irq_b)
  );

  assign dev_run    = csr_q[B_RUN];
  assign dev_maint  = csr_q[B_MAINT];
  assign dev_req_in = csr_q[B_REQ_IN];
  assign dev_step   = step_q;
  assign dev_instr  = instr_q;
  assign dev_cmd    = cmd_q;
endmodule

// File: rtl/mbx_csr_irq_chk.sv
module mbx_csr_irq_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [15:0]   csr_q,
  input logic [DW-1:0] outbox_q,
  input logic          irq_a,
  input logic          irq_b,
  input logic          irq_a_ack,
  input logic          irq_b_ack,
  input logic          dev_step,
  input logic          dev_maint
);
  p_vector_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_a |-> csr_q[4]);
  p_vector_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_b |-> csr_q[7]);
  p_enable_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_a |-> csr_q[0]) and (irq_b |-> csr_q[1]));
  p_ack_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_a_ack && irq_a) |=> !irq_a);
  p_ack_drop_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_b_ack && irq_b) |=> !irq_b);
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    csr_q[7] |=> $stable(outbox_q));
  p_run_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_q[15] |=> (!csr_q[4] && !csr_q[7]));
  p_step_maint_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dev_step |-> dev_maint);
endmodule

bind mbx_csr_irq mbx_csr_irq_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .csr_q(csr_q), .outbox_q(outbox_q),
  .irq_a(irq_a), .irq_b(irq_b), .irq_a_ack(irq_a_ack), .irq_b_ack(irq_b_ack),
  .dev_step(dev_step), .dev_maint(dev_maint)
);

// File: tb/sim_mbx_csr_irq.sv
module sim_mbx_csr_irq;
  localparam int DW = 16;
  localparam int AW = 2;
  localparam logic [2:0] RD = 3'd0, WR = 3'd1, ST = 3'd2, CL = 3'd3, TS = 3'd4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic bus_req = 1'b0;
  logic [2:0] bus_op = '0;
  logic [AW-1:0] bus_addr = '0;
  logic [1:0] bus_be = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic dev_run, dev_maint, dev_step, dev_req_in, dev_out_ready, irq_a, irq_b;
  logic [DW-1:0] dev_instr, dev_cmd;
  logic dev_in_grant = 1'b0, dev_out_valid = 1'b0, irq_a_ack = 1'b0, irq_b_ack = 1'b0;
  logic [DW-1:0] dev_out_data = '0;

  mbx_csr_irq #(.DW(DW), .AW(AW)) u0 (.*);

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  be;
    logic [15:0] wd;
    logic [15:0] exp;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{WR, 2'b11, 16'hA5C3, 16'hA5C3},
    '{ST, 2'b01, 16'h000F, 16'hA5CF},
    '{CL, 2'b10, 16'hFF00, 16'h00CF},
    '{ST, 2'b10, 16'h1200, 16'h12CF},
    '{CL, 2'b01, 16'h00C0, 16'h120F},
    '{WR, 2'b01, 16'hFF77, 16'h1277},
    '{ST, 2'b00, 16'hFFFF, 16'h1277},
    '{CL, 2'b11, 16'h0202, 16'h1075}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host(input logic [2:0] op, input int addr, input logic [1:0] be,
                      input logic [15:0] wd, output logic [15:0] rd);
    @(negedge clk);
    bus_req = 1'b1; bus_op = op; bus_addr = AW'(addr); bus_be = be; bus_wdata = wd;
    @(negedge clk);
    bus_req = 1'b0;
    rd = bus_rdata;
  endtask

  task automatic rdchk(input string tag, input int addr, input logic [15:0] exp);
    logic [15:0] v;
    host(RD, addr, 2'b11, 16'h0000, v);
    chk(tag, v, exp);
  endtask

  task automatic pulse_valid(input logic [15:0] d);
    @(negedge clk);
    dev_out_valid = 1'b1; dev_out_data = d;
    @(negedge clk);
    dev_out_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    chk("R1 irq_a", irq_a, 0);
    chk("R1 irq_b", irq_b, 0);
    chk("R1 out_ready", dev_out_ready, 0);
    rdchk("R1 csr", 0, 16'h0000);
    rdchk("R1 instr", 1, 16'h0000);
    rdchk("R1 outbox", 2, 16'h0000);
    rdchk("R1 cmd", 3, 16'h0000);

    // R2 table walk on the command word
    foreach (TBL[i]) begin
      host(TBL[i].op, 3, TBL[i].be, TBL[i].wd, v);
      rdchk($sformatf("R2 vec%0d", i), 3, TBL[i].exp);
      chk($sformatf("R2 dev_cmd vec%0d", i), dev_cmd, TBL[i].exp);
    end
    host(TS, 3, 2'b11, 16'h00F0, v);
    chk("R2 test result", v, 16'h0070);
    rdchk("R2 test no change", 3, 16'h1075);

    // R3 / R6: request input raises vector A
    host(WR, 0, 2'b11, 16'h8003, v);
    chk("R3 no irq before request", irq_a, 0);
    host(ST, 0, 2'b01, 16'h0020, v);
    @(negedge clk);
    chk("R3 irq_a", irq_a, 1);
    chk("R6 irq_b stays low", irq_b, 0);
    chk("R3 dev_req_in", dev_req_in, 1);
    rdchk("R3 csr in_ready", 0, 16'h8033);

    // R8 acknowledge
    irq_a_ack = 1'b1;
    @(negedge clk);
    irq_a_ack = 1'b0;
    chk("R8 irq_a after ack", irq_a, 0);
    repeat (3) @(negedge clk);
    chk("R8 no reassert", irq_a, 0);

    // R9 host clear, write-one ignored
    host(CL, 0, 2'b01, 16'h0030, v);
    rdchk("R9 cleared", 0, 16'h8003);
    host(ST, 0, 2'b01, 16'h0090, v);
    rdchk("R9 set ignored", 0, 16'h8003);
    chk("R9 irq_a low", irq_a, 0);
    host(ST, 0, 2'b01, 16'h0020, v);
    @(negedge clk);
    chk("R8 reassert after clear and set", irq_a, 1);
    host(CL, 0, 2'b01, 16'h0030, v);
    chk("R9 irq_a dropped by clear", irq_a, 0);

    // R4 / R6 output transfer
    chk("R4 ready when idle", dev_out_ready, 1);
    pulse_valid(16'hBEEF);
    chk("R4 irq_b", irq_b, 1);
    chk("R6 irq_a stays low", irq_a, 0);
    chk("R4 ready dropped", dev_out_ready, 0);
    rdchk("R4 outbox", 2, 16'hBEEF);
    rdchk("R4 csr out_ready", 0, 16'h8083);

    // R5 overrun attempt
    @(negedge clk);
    dev_out_valid = 1'b1; dev_out_data = 16'h1234;
    repeat (2) @(negedge clk);
    dev_out_valid = 1'b0;
    rdchk("R5 outbox kept", 2, 16'hBEEF);
    chk("R5 irq_b kept", irq_b, 1);
    rdchk("R5 csr kept", 0, 16'h8083);

    // R7 enable gating
    host(CL, 0, 2'b01, 16'h0002, v);
    chk("R7 irq_b gated off", irq_b, 0);
    host(ST, 0, 2'b01, 16'h0002, v);
    chk("R7 irq_b re-enabled", irq_b, 1);
    irq_b_ack = 1'b1;
    @(negedge clk);
    irq_b_ack = 1'b0;
    chk("R8 irq_b after ack", irq_b, 0);
    host(CL, 0, 2'b01, 16'h0080, v);
    chk("R9 out ready returns", dev_out_ready, 1);
    host(CL, 0, 2'b01, 16'h0001, v);
    host(ST, 0, 2'b01, 16'h0020, v);
    @(negedge clk);
    chk("R7 irq_a gated", irq_a, 0);
    rdchk("R7 ready set while gated", 0, 16'h8032);
    host(ST, 0, 2'b01, 16'h0001, v);
    chk("R7 irq_a after enable", irq_a, 1);
    host(CL, 0, 2'b01, 16'h0030, v);

    // R12 device grant
    @(negedge clk);
    dev_in_grant = 1'b1;
    @(negedge clk);
    dev_in_grant = 1'b0;
    chk("R12 irq_a from grant", irq_a, 1);
    rdchk("R12 csr", 0, 16'h8013);
    host(CL, 0, 2'b01, 16'h0010, v);

    // R10 run clear
    host(ST, 0, 2'b01, 16'h0020, v);
    pulse_valid(16'h5A5A);
    chk("R10 both pending a", irq_a, 1);
    chk("R10 both pending b", irq_b, 1);
    host(CL, 0, 2'b10, 16'h8000, v);
    chk("R10 irq_a dropped", irq_a, 0);
    chk("R10 irq_b dropped", irq_b, 0);
    chk("R10 no accept", dev_out_ready, 0);
    rdchk("R10 csr", 0, 16'h0003);
    pulse_valid(16'h7777);
    rdchk("R10 outbox unchanged", 2, 16'h5A5A);
    host(ST, 0, 2'b10, 16'h8000, v);
    @(negedge clk);
    chk("R10 no irq after rerun", irq_a | irq_b, 0);
    rdchk("R10 csr rerun", 0, 16'h8003);

    // R11 maintenance and step
    host(WR, 1, 2'b11, 16'h0ABC, v);
    chk("R11 dev_instr", dev_instr, 16'h0ABC);
    host(ST, 0, 2'b10, 16'h0300, v);
    chk("R11 step pulse", dev_step, 1);
    @(negedge clk);
    chk("R11 step one cycle", dev_step, 0);
    rdchk("R11 step reads zero", 0, 16'h8203);
    host(CL, 0, 2'b10, 16'h0200, v);
    host(ST, 0, 2'b10, 16'h0100, v);
    chk("R11 no step without maint", dev_step, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule